// File: doc/BRIEF.md
# Warp Issue Scheduler

This block tracks the warps resident on one compute core and decides, every clock cycle, which of them issue their next instruction. Each warp slot has three inputs: a resident bit, an operand-ready pulse from the dependency tracker, and a priority value. The scheduler keeps a ready flag for each slot. It forms the set of eligible warps, which are resident warps whose flag is set. From that set it picks up to two warps in the same cycle. The picks appear on two issue ports as strobes with warp IDs. Every thread of a picked warp then executes that warp's single next instruction.

The picks are combinational from the registered slot states. A warp that becomes ready can therefore issue in the very next cycle, and the choice can move to a different warp on every cycle with no dead cycle. Issuing a warp clears its ready flag. The flag is set again only by a new ready pulse. With the default sizing, three resident blocks of 256 threads each give 24 warps of 32 threads, so the default is 24 slots.

Each slot runs a small state machine:
- States: `SLOT_EMPTY` (not resident), `SLOT_WAIT` (resident, operands pending) and `SLOT_READY` (resident and eligible).
- Transitions:
  - *evict*: any state goes to EMPTY when the resident bit is low.
  - *arm*: a resident slot goes to READY on a ready pulse.
  - *admit*: EMPTY goes to WAIT when the resident bit rises with no pulse.
  - *consume*: READY goes to WAIT when the slot issues with no pulse.
  - *hold*: in every other case the slot keeps its state.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every slot is empty and neither issue strobe is asserted until a ready pulse has been seen.
- R2: A warp issues only while its resident bit is high and its ready flag is set. A resident warp that has had no ready pulse never issues.
- R3: Issue port 0 carries the eligible warp with the numerically largest priority value (larger value means more urgent).
- R4: When several eligible warps share the best priority, the lowest warp ID wins. This holds on both ports.
- R5: Issue port 1 carries the best eligible warp other than the one on port 0, chosen by the rules of R3 and R4. Port 1 strobes only when at least two warps are eligible, and its ID always differs from port 0's ID.
- R6: A warp that issues in cycle t has its ready flag cleared from cycle t+1. It does not issue again until a new ready pulse arrives.
- R7: A ready pulse on a resident warp in cycle t makes that warp eligible in cycle t+1. Consecutive cycles may issue different warps with no idle cycle between them.
- R8: When a warp's resident bit is low it cannot issue in that cycle and its ready flag is lost. It needs a fresh ready pulse after it becomes resident again.
- R9: A ready pulse on a non-resident warp is ignored. When the warp later becomes resident it stays ineligible.
- R10: A ready pulse in the same cycle that a warp issues keeps the warp ready, so it can issue again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_resident | input | NUM_WARPS | Per-slot resident bit |
| ready_set | input | NUM_WARPS | Per-slot pulse: operands of next instruction ready |
| warp_prio | input | NUM_WARPS*PRIO_W | Priority per slot, slot i at bits [i*PRIO_W +: PRIO_W] |
| issue0_vld | output | 1 | Strobe for the first issue port |
| issue0_id | output | ID_W | Warp ID on the first issue port |
| issue1_vld | output | 1 | Strobe for the second issue port |
| issue1_id | output | ID_W | Warp ID on the second issue port |

## Verification
The bench builds the block with 8 slots and a 2-bit priority. With only four priority levels, ties between eligible warps are frequent, so the lowest-ID tie rule is exercised on both ports. Eight slots keep the highest ID and the eviction, re-admission and same-cycle re-arm corners reachable in short directed sequences. A randomized stretch then mixes resident bits, pulses and priorities.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/warp_slot_fsm.sv
module warp_slot_fsm
    import sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resident,
    input  logic arm,
    input  logic issued,
    output logic eligible
);
    slot_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (resident) state_d = arm ? SLOT_READY : SLOT_WAIT;
            end
            SLOT_WAIT: begin
                if (!resident)  state_d = SLOT_EMPTY;
                else if (arm)   state_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (!resident)   state_d = SLOT_EMPTY;
                else if (arm)    state_d = SLOT_READY;
                else if (issued) state_d = SLOT_WAIT;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        eligible = (state_q == SLOT_READY) && resident;
    end

    AST_EVICT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !resident |=> !eligible); // R8
    AST_ARM_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (resident && arm) |=> (state_q == SLOT_READY)); // R7
    AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (resident && issued && !arm) |=> (state_q == SLOT_WAIT)); // R6
endmodule

// File: rtl/warp_pick.sv
module warp_pick #(
    parameter int NUM_WARPS = 24,
    parameter int PRIO_W    = 3,
    localparam int ID_W     = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0]        cand,
    input  logic [NUM_WARPS*PRIO_W-1:0] prio,
    output logic                        pick_vld,
    output logic [ID_W-1:0]             pick_id
);
    logic [PRIO_W-1:0] best_p;

    // ascending scan with strict compare: ties stay with the lower ID
    always_comb begin
        pick_vld = 1'b0;
        pick_id  = '0;
        best_p   = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (cand[i] && (!pick_vld || prio[i*PRIO_W +: PRIO_W] > best_p)) begin
                pick_vld = 1'b1;
                pick_id  = ID_W'(i);
                best_p   = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
    parameter int NUM_WARPS = 24,
    parameter int PRIO_W    = 3,
    localparam int ID_W     = $clog2(NUM_WARPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WARPS-1:0]        warp_resident,
    input  logic [NUM_WARPS-1:0]        ready_set,
    input  logic [NUM_WARPS*PRIO_W-1:0] warp_prio,
    output logic                        issue0_vld,
    output logic [ID_W-1:0]             issue0_id,
    output logic                        issue1_vld,
    output logic [ID_W-1:0]             issue1_id
);
    logic [NUM_WARPS-1:0] elig;
    logic [NUM_WARPS-1:0] elig_rest;
    logic [NUM_WARPS-1:0] issued;

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
        assign issued[g] = (issue0_vld && issue0_id == ID_W'(g))
                        || (issue1_vld && issue1_id == ID_W'(g));
        assign elig_rest[g] = elig[g] && !(issue0_vld && issue0_id == ID_W'(g));

        warp_slot_fsm u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .resident (warp_resident[g]),
            .arm      (ready_set[g]),
            .issued   (issued[g]),
            .eligible (elig[g])
        );
    end

    warp_pick #(.NUM_WARPS(NUM_WARPS), .PRIO_W(PRIO_W)) u_pick0 (
        .cand     (elig),
        .prio     (warp_prio),
        .pick_vld (issue0_vld),
        .pick_id  (issue0_id)
    );

    warp_pick #(.NUM_WARPS(NUM_WARPS), .PRIO_W(PRIO_W)) u_pick1 (
        .cand     (elig_rest),
        .prio     (warp_prio),
        .pick_vld (issue1_vld),
        .pick_id  (issue1_id)
    );

    AST_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_vld |-> (issue0_vld && issue1_id != issue0_id)); // R5
    AST_ISSUE_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        issue0_vld |-> warp_resident[issue0_id]); // R2
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0_vld && !ready_set[issue0_id]) |=> !(issue0_vld && issue0_id == $past(issue0_id))); // R6

    always_ff @(posedge clk) begin
        if (rst_n && issue0_vld) begin
            for (int i = 0; i < NUM_WARPS; i++) begin
                AST_SLOT0_BEST: assert (!(elig[i] &&
                    warp_prio[i*PRIO_W +: PRIO_W] > warp_prio[issue0_id*PRIO_W +: PRIO_W])); // R3
            end
        end
    end
endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
    localparam int N  = 8;
    localparam int PW = 2;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  res = '0;
    logic [N-1:0]  set = '0;
    logic [N*PW-1:0] pr = '0;
    logic          v0, v1;
    logic [IW-1:0] i0, i1;

    always #4 clk = ~clk; // 125 MHz

    warp_issue_sched #(.NUM_WARPS(N), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .warp_resident(res), .ready_set(set),
        .warp_prio(pr), .issue0_vld(v0), .issue0_id(i0),
        .issue1_vld(v1), .issue1_id(i1)
    );

    typedef struct {
        logic          ev0;
        logic [IW-1:0] ei0;
        logic          ev1;
        logic [IW-1:0] ei1;
        string         tag;
    } exp_t;

    exp_t   q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    logic [N-1:0] mrdy = '0;
    bit     done = 0;

    task automatic pick(input logic [N-1:0] c, input logic [N*PW-1:0] p,
                        output logic v, output logic [IW-1:0] id);
        int bp = -1;
        v = 0; id = '0;
        for (int i = 0; i < N; i++) begin
            if (c[i] && int'(p[i*PW +: PW]) > bp) begin
                bp = int'(p[i*PW +: PW]); v = 1; id = IW'(i);
            end
        end
    endtask

    // driver: apply one cycle of stimulus and push the expected issue
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] s,
                        input logic [N*PW-1:0] p, input string tag);
        exp_t e;
        logic [N-1:0] c;
        @(negedge clk); #1;
        res = r; set = s; pr = p;
        c = mrdy & r;
        pick(c, p, e.ev0, e.ei0);
        if (e.ev0) c[e.ei0] = 1'b0;
        pick(c, p, e.ev1, e.ei1);
        e.tag = tag;
        q.push_back(e);
        for (int i = 0; i < N; i++) begin
            if (!r[i])      mrdy[i] = 1'b0;
            else if (s[i])  mrdy[i] = 1'b1;
            else if ((e.ev0 && e.ei0 == IW'(i)) || (e.ev1 && e.ei1 == IW'(i))) mrdy[i] = 1'b0;
        end
    endtask

    // monitor: compare outputs against the queue between edges
    initial begin
        forever begin
            @(negedge clk); #3;
            if (q.size() > 0) begin
                exp_t e;
                bit bad;
                e = q.pop_front();
                n_cmp++;
                bad = (v0 !== e.ev0) || (e.ev0 && i0 !== e.ei0) ||
                      (v1 !== e.ev1) || (e.ev1 && i1 !== e.ei1);
                if (bad) begin
                    n_bad++;
                    $display("FAIL %s: got v0=%0b id0=%0d v1=%0b id1=%0d, expected v0=%0b id0=%0d v1=%0b id1=%0d",
                             e.tag, v0, i0, v1, i1, e.ev0, e.ei0, e.ev1, e.ei1);
                end
            end
        end
    end

    function automatic logic [N*PW-1:0] pset(input logic [N*PW-1:0] b, input int idx, input int val);
        logic [N*PW-1:0] r = b;
        r[idx*PW +: PW] = PW'(val);
        return r;
    endfunction

    initial begin
        logic [N*PW-1:0] p;
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst_n = 1'b1;
        // R1: reset state, no strobes
        @(negedge clk); #3;
        n_cmp++;
        if (v0 !== 1'b0 || v1 !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got v0=%0b v1=%0b, expected 0 0", v0, v1);
        end
        step(8'hFF, 8'h00, '0, "R1");
        step(8'hFF, 8'h00, '0, "R2");           // resident, not ready
        // R3/R5/R7: warps 2 (prio 1) and 5 (prio 3)
        p = pset(pset('0, 2, 1), 5, 3);
        step(8'hFF, 8'h24, p, "R7");            // pulse cycle: nothing yet
        step(8'hFF, 8'h00, p, "R3");            // 5 then 2
        step(8'hFF, 8'h00, p, "R6");            // both consumed
        // R4: ties among 1,3,6 at prio 2
        p = pset(pset(pset('0, 1, 2), 3, 2), 6, 2);
        step(8'hFF, 8'h4A, p, "R4");
        step(8'hFF, 8'h00, p, "R4");            // 1 and 3
        step(8'hFF, 8'h00, p, "R5");            // only 6, port 1 idle
        step(8'hFF, 8'h00, p, "R6");
        // R9: pulse on non-resident warp 4
        step(8'hEF, 8'h10, '0, "R9");
        step(8'hFF, 8'h00, '0, "R9");
        step(8'hFF, 8'h00, '0, "R9");
        // R8: warp 0 armed then evicted
        step(8'hFF, 8'h01, '0, "R8");
        step(8'hFE, 8'h00, '0, "R8");           // not resident: blocked
        step(8'hFF, 8'h00, '0, "R8");           // flag lost
        // R10: warp 7 re-armed while issuing, back-to-back
        p = pset('0, 7, 3);
        step(8'hFF, 8'h80, p, "R10");
        step(8'hFF, 8'h80, p, "R10");
        step(8'hFF, 8'h00, p, "R10");
        step(8'hFF, 8'h00, p, "R10");
        // R7: different warps on consecutive cycles
        p = pset(pset('0, 0, 3), 7, 0);
        step(8'hFF, 8'h81, p, "R7");
        step(8'hFF, 8'h00, p, "R7");
        step(8'hFF, 8'h00, p, "R7");
        // randomized mix
        for (int k = 0; k < 300; k++) begin
            step(N'($urandom | $urandom), N'($urandom & $urandom), (N*PW)'($urandom), "R5");
        end
        step(8'hFF, 8'h00, '0, "R3");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule